// File: doc/BRIEF.md
# Dual-Port Shifting Register File

This block is a small word store with two read ports and one write port, meant to sit in one slice of a bit-sliced datapath. Two independent addresses (A and B) select the words that appear on the two read outputs. The single write port always stores into the word selected by the B address. This matches the common "B is both source and destination" micro-operation.

The write data is the arithmetic result of the slice, fed through a three-way shift multiplexer. The multiplexer passes the result unchanged, or moves it one bit toward the most significant end, or one bit toward the least significant end. The bit that a shift vacates is taken from a bidirectional serial pin shared with the neighbouring slice. The bit that leaves the word is driven out on the opposite pin. Chaining these pins across slices gives a shift of any word length.

Each read port drives a level-sensitive latch. The latch follows the array while the clock is high and holds while it is low. The array is written at the falling edge, so read data seen during a cycle is never disturbed by that cycle's own write.

Top module: `regfile_shift_dp`

## Requirements
- R1: When `rst_n` is low at a falling clock edge, every word is cleared to 0; after reset every address reads 0 on both ports.
- R2: During the high clock phase, `rd_a` shows the word at `addr_a` and `rd_b` shows the word at `addr_b`, with both addresses chosen independently.
- R3: When `addr_a` equals `addr_b`, `rd_a` and `rd_b` show the same stored word.
- R4: When `wr_en` is high at a falling edge, only the word at `addr_b` is replaced; all other words keep their value, and nothing changes when `wr_en` is low.
- R5: With `shift_sel` = 2'b00 (or the spare code 2'b11), the stored word equals `alu_f` unchanged.
- R6: With `shift_sel` = 2'b01 (up), the stored word is {`alu_f`[2:0], `ser_lo`}, and the block drives `alu_f`[3] onto `ser_hi`.
- R7: With `shift_sel` = 2'b10 (down), the stored word is {`ser_hi`, `alu_f`[3:1]}, and the block drives `alu_f`[0] onto `ser_lo`.
- R8: With `shift_sel` = 2'b00 or 2'b11, the block drives neither serial pin, so a value placed on a pin from outside reads back unchanged.
- R9: The read latches hold during the low phase. After a write to the word being read, the read output shows the old data until the next rising edge and the new data from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; high phase reads, falling edge writes |
| rst_n | input | 1 | Synchronous active-low reset, sampled on the falling edge |
| addr_a | input | 4 | Read address of port A |
| addr_b | input | 4 | Read address of port B and write address |
| wr_en | input | 1 | Write enable, sampled on the falling edge |
| shift_sel | input | 2 | 00 pass, 01 up, 10 down, 11 pass |
| alu_f | input | 4 | Result word to be stored |
| ser_lo | inout | 1 | Low-end serial bit: input on up shift, output on down shift |
| ser_hi | inout | 1 | High-end serial bit: output on up shift, input on down shift |
| rd_a | output | 4 | Latched read data of port A |
| rd_b | output | 4 | Latched read data of port B |

## Verification
The bench builds the block with its default 4-bit width and 16-word depth. At that size every address pair can be read, and every result value can be stored under each shift code with both serial-input values. All 256 A/B pairs are read back against a model kept in the bench, which covers port independence and equal addresses in full. Same-address write-while-read is checked at three points: in the high phase, just after the falling edge, and after the next rising edge.

// File: rtl/rfs_pkg.sv
// Shared types for the dual-port shifting register file.
package rfs_pkg;
    // Shift selection for the write path; the spare code behaves as pass.
    typedef enum logic [1:0] {
        SH_PASS  = 2'b00,
        SH_UP    = 2'b01,
        SH_DOWN  = 2'b10,
        SH_SPARE = 2'b11
    } shift_e;
endpackage

// File: rtl/rfs_shifter.sv
// Write-path shift multiplexer.
// Passes the result word, or moves it one bit up or down. The vacated end
// bit comes from the neighbour's serial pin, and the bit leaving the word
// is offered for the opposite pin with an output enable.
// Assumes W >= 2. Pin tri-stating is done by the parent.
module rfs_shifter #(
    parameter int W = 4
) (
    input  rfs_pkg::shift_e sel,
    input  logic [W-1:0]    f,
    input  logic            lo_in,
    input  logic            hi_in,
    output logic [W-1:0]    wdata,
    output logic            lo_out,
    output logic            lo_oe,
    output logic            hi_out,
    output logic            hi_oe
);
    import rfs_pkg::*;

    // Select the stored word and the serial pin enables.
    always_comb begin
        wdata  = f;
        lo_out = f[0];
        hi_out = f[W-1];
        lo_oe  = 1'b0;
        hi_oe  = 1'b0;
        case (sel)
            SH_UP: begin
                wdata = {f[W-2:0], lo_in};
                hi_oe = 1'b1;
            end
            SH_DOWN: begin
                wdata = {hi_in, f[W-1:1]};
                lo_oe = 1'b1;
            end
            default: wdata = f;
        endcase
    end
endmodule

// File: rtl/rfs_array.sv
// Word storage with two combinational read ports and one write port.
// Writes and synchronous clears happen on the falling clock edge, so the
// high-phase read path is settled before storage changes.
module rfs_array #(
    parameter int W     = 4,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  qa,
    output logic [W-1:0]  qb
);
    logic [W-1:0] mem [DEPTH];

    // Clear on reset, otherwise store into the B-addressed word.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[rb] <= wdata;
        end
    end

    // Two independent read ports.
    assign qa = mem[ra];
    assign qb = mem[rb];

    // R1: a falling edge with reset low leaves addressed words at zero.
    a_r1_clear: assert property (@(negedge clk)
        !rst_n |=> (mem[ra] == '0 && mem[rb] == '0));

    // R4: an enabled write lands in the word addressed by B.
    a_r4_write_b: assert property (@(negedge clk) disable iff (!rst_n)
        we |=> mem[$past(rb)] == $past(wdata));
endmodule

// File: rtl/rfs_rdlatch.sv
// Read-data latch: transparent while the clock is high, holding while low.
// Assumes the storage behind it changes only on the falling edge.
module rfs_rdlatch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Level-sensitive capture during the high phase.
    always_latch begin
        if (clk) q = d;
    end

    // Checker state: the value held when the low phase starts.
    logic [W-1:0] low_copy;
    logic         low_seen;
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            low_seen <= 1'b0;
            low_copy <= '0;
        end else begin
            low_seen <= 1'b1;
            low_copy <= q;
        end
    end

    // R9: the output does not move during the low phase.
    a_r9_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        low_seen |-> q == low_copy);
endmodule

// File: rtl/regfile_shift_dp.sv
// Dual-port shifting register file, one slice of a cascadable datapath.
// Reads are latched on the high clock phase. The write goes to the B word
// on the falling edge, through the up/down/pass shifter, with serial end
// bits exchanged with neighbouring slices over two bidirectional pins.
module regfile_shift_dp #(
    parameter int W     = 4,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    input  logic          wr_en,
    input  logic [1:0]    shift_sel,
    input  logic [W-1:0]  alu_f,
    inout  wire           ser_lo,
    inout  wire           ser_hi,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);
    import rfs_pkg::*;

    shift_e       sel;
    logic [W-1:0] wdata, qa, qb;
    logic         lo_out, lo_oe, hi_out, hi_oe;

    assign sel = shift_e'(shift_sel);

    rfs_shifter #(.W(W)) u_shift (
        .sel(sel), .f(alu_f), .lo_in(ser_lo), .hi_in(ser_hi),
        .wdata(wdata), .lo_out(lo_out), .lo_oe(lo_oe),
        .hi_out(hi_out), .hi_oe(hi_oe)
    );

    // Serial pins are driven only by the shift that exports a bit.
    assign ser_lo = lo_oe ? lo_out : 1'bz;
    assign ser_hi = hi_oe ? hi_out : 1'bz;

    rfs_array #(.W(W), .DEPTH(DEPTH)) u_array (
        .clk(clk), .rst_n(rst_n), .ra(addr_a), .rb(addr_b),
        .we(wr_en), .wdata(wdata), .qa(qa), .qb(qb)
    );

    rfs_rdlatch #(.W(W)) u_lat_a (.clk(clk), .rst_n(rst_n), .d(qa), .q(rd_a));
    rfs_rdlatch #(.W(W)) u_lat_b (.clk(clk), .rst_n(rst_n), .d(qb), .q(rd_b));

    // R3: equal addresses give equal read data at the end of the high phase.
    a_r3_same_word: assert property (@(negedge clk) disable iff (!rst_n)
        (addr_a == addr_b) |-> rd_a == rd_b);

    // R6: an up shift exports the top result bit on the high pin.
    a_r6_up_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_sel == 2'b01) |-> ser_hi == alu_f[W-1]);

    // R7: a down shift exports the bottom result bit on the low pin.
    a_r7_down_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_sel == 2'b10) |-> ser_lo == alu_f[0]);
endmodule

// File: tb/sim_regfile_shift_dp.sv
module sim_regfile_shift_dp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr_a = '0, addr_b = '0, alu_f = '0;
    logic       wr_en = 1'b0;
    logic [1:0] shift_sel = 2'b00;
    logic       lo_en = 1'b0, lo_v = 1'b0, hi_en = 1'b0, hi_v = 1'b0;
    wire        ser_lo, ser_hi;
    logic [3:0] rd_a, rd_b;
    logic [3:0] model [16];
    int         n_chk = 0, n_fail = 0;

    assign ser_lo = lo_en ? lo_v : 1'bz;
    assign ser_hi = hi_en ? hi_v : 1'bz;

    always #5 clk = ~clk;

    regfile_shift_dp u0 (
        .clk(clk), .rst_n(rst_n), .addr_a(addr_a), .addr_b(addr_b),
        .wr_en(wr_en), .shift_sel(shift_sel), .alu_f(alu_f),
        .ser_lo(ser_lo), .ser_hi(ser_hi), .rd_a(rd_a), .rd_b(rd_b)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read two addresses for one cycle and compare both ports (R2, R3).
    task automatic rd(input logic [3:0] a, input logic [3:0] b, input string req);
        @(negedge clk); #1;
        addr_a = a; addr_b = b; wr_en = 0; shift_sel = 2'b00;
        lo_en = 0; hi_en = 0;
        @(posedge clk); #2;
        check(req, rd_a, model[a]);
        check(req, rd_b, model[b]);
    endtask

    // Apply one write; it lands at the falling edge after this task returns.
    task automatic wr(input logic [3:0] b, input logic [3:0] f, input logic [1:0] sh,
                      input logic lo, input logic hi);
        logic [3:0] exp;
        @(negedge clk); #1;
        addr_a = b ^ 4'h1; addr_b = b; alu_f = f; wr_en = 1; shift_sel = sh;
        lo_en = (sh != 2'b10); lo_v = lo;
        hi_en = (sh != 2'b01); hi_v = hi;
        @(posedge clk); #2;
        case (sh)
            2'b01: begin
                exp = {f[2:0], lo};
                check("R6 hi pin", {3'b0, ser_hi}, {3'b0, f[3]});
            end
            2'b10: begin
                exp = {hi, f[3:1]};
                check("R7 lo pin", {3'b0, ser_lo}, {3'b0, f[0]});
            end
            default: begin
                exp = f;
                check("R8 lo pin free", {3'b0, ser_lo}, {3'b0, lo});
                check("R8 hi pin free", {3'b0, ser_hi}, {3'b0, hi});
            end
        endcase
        model[b] = exp;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 4'h0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R1: every word reads zero after reset
        for (int i = 0; i < 16; i++) rd(i[3:0], 4'(15 - i), "R1 reset clear");

        // R5: plain writes to every word, then R2/R3 full pair sweep
        for (int i = 0; i < 16; i++) wr(i[3:0], 4'((i * 7 + 3) & 15), 2'b00, 1'b0, 1'b1);
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                rd(a[3:0], b[3:0], (a == b) ? "R3 same address" : "R2 independent read");

        // R6/R7/R5: every result value under each shift code and pin value
        for (int f = 0; f < 16; f++)
            for (int s = 0; s < 4; s++)
                for (int p = 0; p < 2; p++) begin
                    wr(4'(f), 4'(f), 2'(s), p[0], ~p[0]);
                    rd(4'(f), 4'(f), (s == 1) ? "R6 up store" :
                                     (s == 2) ? "R7 down store" : "R5 pass store");
                end

        // R4: write disabled leaves the word; write touches only B word
        @(negedge clk); #1;
        addr_a = 4'h5; addr_b = 4'h5; alu_f = ~model[5]; wr_en = 0; shift_sel = 2'b00;
        lo_en = 0; hi_en = 0;
        @(posedge clk); #2;
        rd(4'h5, 4'h6, "R4 no write when disabled");
        wr(4'h9, 4'hA, 2'b00, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) rd(i[3:0], 4'h9, "R4 only B word written");

        // R9: write the word being read; old data until next rising edge
        rd(4'h3, 4'h3, "R9 setup");
        begin
            logic [3:0] old_v, new_v;
            old_v = model[3];
            new_v = ~old_v;
            @(negedge clk); #1;
            addr_a = 4'h3; addr_b = 4'h3; alu_f = new_v; wr_en = 1; shift_sel = 2'b00;
            lo_en = 1; hi_en = 1;
            @(posedge clk); #2;
            check("R9 high phase old", rd_a, old_v);
            @(negedge clk); #1;
            wr_en = 0;
            check("R9 low phase old A", rd_a, old_v);
            check("R9 low phase old B", rd_b, old_v);
            @(posedge clk); #2;
            check("R9 next high new A", rd_a, new_v);
            check("R9 next high new B", rd_b, new_v);
            model[3] = new_v;
        end
        rd(4'h3, 4'h0, "R9 stored");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule